// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit handles a family of eight bit-field instructions on 32-bit and 64-bit operands. An extract pulls a contiguous field out of the source operand, shifts it down to bit 0 and fills the bits above it with zeros. An insert takes the low bits of the source operand and writes them into a field of the current destination value. All destination bits outside that field keep their old value.

The field bounds come from two 5-bit fields of the instruction word. Because 5 bits only reach bit 31, the doubleword variants reach the upper half of the operand by adding 32 to the upper bound, to the lower bound, or to both. The function code selects which of these adjustments applies. The word forms work in the low 32 bits and sign-extend their result from bit 31.

The result is registered and appears one cycle after the input strobe, together with the destination register index. A doubleword form that arrives while 64-bit operation is disabled produces a one-cycle fault pulse and no result. Register-file access and forwarding belong to the surrounding pipeline.

Top module: `bitfield_xu`

## Requirements
- R1: An accepted instruction (in_valid high, recognised encoding, legal in the current mode) raises out_valid exactly one cycle later, with out_dest equal to instruction bits [20:16]. In a cycle after in_valid was low, out_valid and out_illegal are both low.
- R2: An instruction belongs to the family only when bits [31:26] are 011111 and bits [5:3] are 000. Any other encoding is ignored: neither out_valid nor out_illegal is raised.
- R3: Word extract (bits [5:0] = 000000) takes the field that starts at lsb (bits [10:6]) and has length size+1 (size in bits [15:11]). Source bits above 31 are never used, so a field that crosses bit 31 is cut off there. The field is right-justified and zero-filled, and the 32-bit result is sign-extended from bit 31.
- R4: Doubleword extract (000011) takes a field of length size+1 that starts at lsb. The field is right-justified, and all bits above it are zero.
- R5: Extract with upper bound adjusted (000001) takes a field of length size+33 that starts at lsb. Any part of the field above bit 63 is dropped.
- R6: Extract with lower bound adjusted (000010) takes a field of length size+1 that starts at lsb+32. Any part of the field above bit 63 is dropped.
- R7: Word insert (000100) puts src_a bits [msb-lsb:0] into bits msb..lsb of dst_old (msb in bits [15:11]). The other low 32 bits of dst_old are kept, and the 32-bit result is sign-extended from bit 31.
- R8: Doubleword insert (000111) puts src_a into bits msb..lsb of dst_old and keeps all other 64 bits.
- R9: Insert with upper bound adjusted (000101) puts src_a into bits msb+32..lsb of dst_old and keeps all other bits.
- R10: Insert with both bounds adjusted (000110) puts src_a into bits msb+32..lsb+32 of dst_old and keeps all other bits.
- R11: The six doubleword codes (000001, 000010, 000011, 000101, 000110, 000111) need in_wide_en high. When in_wide_en is low, the unit pulses out_illegal for one cycle one clock later and keeps out_valid low. The word forms do not depend on in_wide_en.
- R12: An insert whose upper bound is below its lower bound has an empty mask. It returns dst_old unchanged, sign-extended from bit 31 for the word form. It raises no fault.
- R13: While rst_n is low, out_valid and out_illegal are low and out_data and out_dest are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| src_a | input | 64 | Source operand (field source) |
| dst_old | input | 64 | Current value of the destination register |
| in_wide_en | input | 1 | 64-bit operation enabled |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 64 | Registered result |
| out_dest | output | 5 | Destination register index |
| out_illegal | output | 1 | Doubleword form issued without 64-bit mode |

## Verification
The properties assume that in_valid is a clean single-cycle strobe, so every output pulse can be traced to the previous cycle's inputs. They also assume that in_instr and in_wide_en are held steady with it. The bench holds every input stable from one falling edge to the next and drops in_valid between instructions, so each result is sampled on its own. The sign-extension and zero-fill properties read the function and size fields one cycle back. The bench's instruction words therefore always carry the fields the requirement under test defines, including bounds that run past bit 31 or bit 63 and inserts with an inverted range.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int BFX_DATA_W = 64;
  localparam int BFX_HALF_W = BFX_DATA_W / 2;
  localparam int BFX_IDX_W  = $clog2(BFX_DATA_W);
  localparam int BFX_FLD_W  = $clog2(BFX_HALF_W);
  localparam int BFX_HI_W   = BFX_IDX_W + 1;
  localparam int BFX_REG_W  = 5;

  localparam logic [5:0] BFX_MAJOR = 6'b011111;

  typedef enum logic [2:0] {
    OP_EXT_W  = 3'b000,
    OP_EXT_DM = 3'b001,
    OP_EXT_DU = 3'b010,
    OP_EXT_D  = 3'b011,
    OP_INS_W  = 3'b100,
    OP_INS_DM = 3'b101,
    OP_INS_DU = 3'b110,
    OP_INS_D  = 3'b111
  } bfx_op_e;

  typedef struct packed {
    logic                 accept;
    logic                 fault;
    logic                 is_ins;
    logic                 is_word;
    logic [BFX_HI_W-1:0]  hi;
    logic [BFX_IDX_W-1:0] lo;
    logic [BFX_REG_W-1:0] dest;
  } bfx_ctrl_t;

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  input  logic        in_wide_en,
  output bfx_ctrl_t   ctrl
);

  localparam logic [BFX_HI_W-1:0] HALF_HI  = BFX_HI_W'(BFX_HALF_W);
  localparam logic [BFX_HI_W-1:0] WORD_TOP = BFX_HI_W'(BFX_HALF_W - 1);

  logic [5:0]           major;
  logic [5:0]           func;
  logic [BFX_FLD_W-1:0] upper_fld;
  logic [BFX_FLD_W-1:0] lower_fld;
  logic                 family;
  logic                 dword;
  bfx_op_e              op;
  logic [BFX_HI_W-1:0]  up_ext;
  logic [BFX_HI_W-1:0]  lo_ext;
  logic [BFX_HI_W-1:0]  ext_top;
  logic [BFX_HI_W-1:0]  lo_sum;
  logic [BFX_HI_W-1:0]  hi_sum;
  logic                 unused_src_idx;

  assign major          = in_instr[31:26];
  assign func           = in_instr[5:0];
  assign upper_fld      = in_instr[15:11];
  assign lower_fld      = in_instr[10:6];
  assign unused_src_idx = ^in_instr[25:21];
  assign op             = bfx_op_e'(func[2:0]);

  assign family = (major == BFX_MAJOR) && (func[5:3] == 3'b000);
  assign dword  = (op != OP_EXT_W) && (op != OP_INS_W);

  assign up_ext  = {{(BFX_HI_W-BFX_FLD_W){1'b0}}, upper_fld};
  assign lo_ext  = {{(BFX_HI_W-BFX_FLD_W){1'b0}}, lower_fld};
  assign ext_top = lo_ext + up_ext;

  always_comb begin
    lo_sum = lo_ext;
    hi_sum = up_ext;
    unique case (op)
      OP_EXT_W:  hi_sum = (ext_top > WORD_TOP) ? WORD_TOP : ext_top;
      OP_EXT_D:  hi_sum = ext_top;
      OP_EXT_DM: hi_sum = ext_top + HALF_HI;
      OP_EXT_DU: begin
        lo_sum = lo_ext + HALF_HI;
        hi_sum = ext_top + HALF_HI;
      end
      OP_INS_W,
      OP_INS_D:  hi_sum = up_ext;
      OP_INS_DM: hi_sum = up_ext + HALF_HI;
      OP_INS_DU: begin
        lo_sum = lo_ext + HALF_HI;
        hi_sum = up_ext + HALF_HI;
      end
      default:   hi_sum = up_ext;
    endcase
  end

  always_comb begin
    ctrl.accept  = in_valid && family && (!dword || in_wide_en);
    ctrl.fault   = in_valid && family && dword && !in_wide_en;
    ctrl.is_ins  = func[2];
    ctrl.is_word = !dword;
    ctrl.hi      = hi_sum;
    ctrl.lo      = lo_sum[BFX_IDX_W-1:0];
    ctrl.dest    = in_instr[20:16];
  end

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W),
  parameter int HI_W   = IDX_W + 1
) (
  input  logic [HI_W-1:0]   hi,
  input  logic [IDX_W-1:0]  lo,
  output logic [DATA_W-1:0] mask
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [HI_W-1:0]   TOP_BIT  = HI_W'(DATA_W - 1);

  logic [DATA_W-1:0] from_lo;
  logic [DATA_W-1:0] to_hi;
  logic [HI_W-1:0]   hi_plus;

  assign hi_plus = hi + HI_W'(1);
  assign from_lo = ALL_ONES << lo;

  always_comb begin
    if (hi >= TOP_BIT) begin
      to_hi = ALL_ONES;
    end else begin
      to_hi = ~(ALL_ONES << hi_plus);
    end
  end

  assign mask = from_lo & to_hi;

endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
(
  input  bfx_ctrl_t              ctrl,
  input  logic [BFX_DATA_W-1:0]  src_a,
  input  logic [BFX_DATA_W-1:0]  dst_old,
  output logic [BFX_DATA_W-1:0]  result
);

  logic [BFX_DATA_W-1:0] mask;
  logic [BFX_DATA_W-1:0] ext_raw;
  logic [BFX_DATA_W-1:0] ins_raw;
  logic [BFX_DATA_W-1:0] raw;

  bfx_mask #(
    .DATA_W (BFX_DATA_W),
    .IDX_W  (BFX_IDX_W),
    .HI_W   (BFX_HI_W)
  ) u_mask (
    .hi   (ctrl.hi),
    .lo   (ctrl.lo),
    .mask (mask)
  );

  assign ext_raw = (src_a & mask) >> ctrl.lo;
  assign ins_raw = dst_old ^ ((dst_old ^ (src_a << ctrl.lo)) & mask);
  assign raw     = ctrl.is_ins ? ins_raw : ext_raw;

  always_comb begin
    if (ctrl.is_word) begin
      result = {{BFX_HALF_W{raw[BFX_HALF_W-1]}}, raw[BFX_HALF_W-1:0]};
    end else begin
      result = raw;
    end
  end

endmodule

// File: rtl/bitfield_xu.sv
module bitfield_xu
  import bfx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  input  logic [63:0] src_a,
  input  logic [63:0] dst_old,
  input  logic        in_wide_en,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic [4:0]  out_dest,
  output logic        out_illegal
);

  bfx_ctrl_t             ctrl;
  logic [BFX_DATA_W-1:0] result;

  logic                  valid_d;
  logic                  illegal_d;
  logic                  data_en;
  logic [BFX_DATA_W-1:0] data_d;
  logic [BFX_REG_W-1:0]  dest_d;

  bfx_decode u_decode (
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .in_wide_en (in_wide_en),
    .ctrl       (ctrl)
  );

  bfx_datapath u_datapath (
    .ctrl    (ctrl),
    .src_a   (src_a),
    .dst_old (dst_old),
    .result  (result)
  );

  always_comb begin
    valid_d   = ctrl.accept;
    illegal_d = ctrl.fault;
    data_en   = ctrl.accept;
    data_d    = out_data;
    dest_d    = out_dest;
    if (data_en) begin
      data_d = result;
      dest_d = ctrl.dest;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
      out_dest    <= '0;
    end else begin
      out_valid   <= valid_d;
      out_illegal <= illegal_d;
      out_data    <= data_d;
      out_dest    <= dest_d;
    end
  end

endmodule

// File: rtl/bfx_checker.sv
module bfx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        in_wide_en,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic        out_illegal
);

  logic in_family;
  logic in_dword;

  assign in_family = (in_instr[31:26] == 6'b011111) && (in_instr[5:3] == 3'b000);
  assign in_dword  = (in_instr[2:0] != 3'b000) && (in_instr[2:0] != 3'b100);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));

  p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_family) |=> (!out_valid && !out_illegal));

  p_word_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_instr[5:0]) == 6'b000000))
      |-> (out_data[63:32] == {32{out_data[31]}}));

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_instr[5:0]) == 6'b000011))
      |-> ((out_data >> ({1'b0, $past(in_instr[15:11])} + 6'd1)) == 64'd0));

  p_word_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_instr[5:0]) == 6'b000100))
      |-> (out_data[63:32] == {32{out_data[31]}}));

  p_mode_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_family && in_dword && !in_wide_en) |=> (out_illegal && !out_valid));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

endmodule

bind bitfield_xu bfx_checker u_bfx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .in_wide_en  (in_wide_en),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/tb_bitfield_xu.sv
`timescale 1ns/1ps
module tb_bitfield_xu;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [63:0] src_a;
  logic [63:0] dst_old;
  logic        in_wide_en;
  logic        out_valid;
  logic [63:0] out_data;
  logic [4:0]  out_dest;
  logic        out_illegal;

  int checks;
  int errors;
  bit done;

  bitfield_xu dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .src_a       (src_a),
    .dst_old     (dst_old),
    .in_wide_en  (in_wide_en),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_dest    (out_dest),
    .out_illegal (out_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] enc(input logic [5:0] fn, input logic [4:0] si,
                                      input logic [4:0] ti, input logic [4:0] up,
                                      input logic [4:0] lw);
    return {6'b011111, si, ti, up, lw, fn};
  endfunction

  // Expected value built bit by bit from the requirement text.
  function automatic logic [63:0] model(input logic [5:0] fn, input logic [63:0] a,
                                        input logic [63:0] b, input int up, input int lw);
    logic [63:0] r;
    int start, len, limit, lo, hi;
    r = '0;
    if (fn[2] == 1'b0) begin
      start = lw; len = up + 1; limit = 63;
      if (fn == 6'b000000) limit = 31;
      if (fn == 6'b000001) len = up + 33;
      if (fn == 6'b000010) start = lw + 32;
      for (int i = 0; i < 64; i++)
        if (i < len && start + i <= limit) r[i] = a[start + i];
    end else begin
      lo = lw; hi = up;
      if (fn == 6'b000101) hi = up + 32;
      if (fn == 6'b000110) begin lo = lw + 32; hi = up + 32; end
      for (int i = 0; i < 64; i++)
        r[i] = (i >= lo && i <= hi) ? a[i - lo] : b[i];
    end
    if (fn == 6'b000000 || fn == 6'b000100)
      for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [63:0] a,
                       input logic [63:0] b, input logic wide);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; src_a = a; dst_old = b; in_wide_en = wide;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [5:0] fn, input logic [4:0] up,
                        input logic [4:0] lw, input logic [63:0] a, input logic [63:0] b);
    logic [4:0] ti;
    ti = up ^ lw ^ 5'd9;
    issue(enc(fn, 5'd3, ti, up, lw), a, b, 1'b1);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " dest"}, {59'd0, out_dest}, {59'd0, ti});
    chk({tag, " data"}, out_data, model(fn, a, b, int'(up), int'(lw)));
    @(negedge clk);
    chk({tag, " R1 drop"}, {62'd0, out_valid, out_illegal}, 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; src_a = '0; dst_old = '0; in_wide_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 valid", {63'd0, out_valid}, 64'd0);
    chk("R13 illegal", {63'd0, out_illegal}, 64'd0);
    chk("R13 data", out_data, 64'd0);
    chk("R13 dest", {59'd0, out_dest}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_word_extract;
    run_op("R3 mid", 6'b000000, 5'd7, 5'd4, 64'hFFFF_0000_1234_5678, 64'h0);
    run_op("R3 full", 6'b000000, 5'd31, 5'd0, 64'h0000_0000_8000_0001, 64'h0);
    run_op("R3 trunc", 6'b000000, 5'd20, 5'd20, 64'hFFFF_FFFF_FFF0_0000, 64'h0);
  endtask

  task automatic t_dext;
    run_op("R4 top", 6'b000011, 5'd31, 5'd31, 64'hDEAD_BEEF_CAFE_F00D, 64'h1);
    run_op("R4 small", 6'b000011, 5'd3, 5'd8, 64'h0000_0000_0000_0A5F, 64'h0);
  endtask

  task automatic t_dextm;
    run_op("R5 all", 6'b000001, 5'd31, 5'd0, 64'h8123_4567_89AB_CDEF, 64'h0);
    run_op("R5 mid", 6'b000001, 5'd10, 5'd20, 64'hF0F0_1234_5678_9ABC, 64'h0);
    run_op("R5 trunc", 6'b000001, 5'd31, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
  endtask

  task automatic t_dextu;
    run_op("R6 bit63", 6'b000010, 5'd0, 5'd31, 64'h8000_0000_0000_0000, 64'h0);
    run_op("R6 trunc", 6'b000010, 5'd31, 5'd16, 64'hABCD_1234_FFFF_FFFF, 64'h0);
    run_op("R6 low", 6'b000010, 5'd7, 5'd0, 64'h0000_005A_0000_0000, 64'h0);
  endtask

  task automatic t_ins;
    run_op("R7 mid", 6'b000100, 5'd15, 5'd8, 64'h0000_0000_0000_00C3, 64'hFFFF_FFFF_1111_1111);
    run_op("R7 full", 6'b000100, 5'd31, 5'd0, 64'h1234_5678_9ABC_DEF0, 64'h0);
    run_op("R7 top", 6'b000100, 5'd31, 5'd28, 64'h0000_0000_0000_0005, 64'h0000_0000_0FFF_FFFF);
  endtask

  task automatic t_dins;
    run_op("R8 mid", 6'b000111, 5'd20, 5'd4, 64'h0000_0000_000F_FFFF, 64'hAAAA_AAAA_AAAA_AAAA);
    run_op("R8 low", 6'b000111, 5'd0, 5'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_dinsm;
    run_op("R9 wide", 6'b000101, 5'd31, 5'd0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R9 span", 6'b000101, 5'd3, 5'd28, 64'h0000_0000_0000_0ABC, 64'h5555_5555_5555_5555);
  endtask

  task automatic t_dinsu;
    run_op("R10 top", 6'b000110, 5'd31, 5'd24, 64'h0000_0000_0000_00E7, 64'h0);
    run_op("R10 mid", 6'b000110, 5'd15, 5'd0, 64'h0000_0000_0000_BEEF, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_mode_fault;
    logic [5:0] dfn [6];
    dfn = '{6'b000001, 6'b000010, 6'b000011, 6'b000101, 6'b000110, 6'b000111};
    for (int k = 0; k < 6; k++) begin
      issue(enc(dfn[k], 5'd1, 5'd2, 5'd4, 5'd4), 64'hFF, 64'h0, 1'b0);
      chk("R11 fault", {63'd0, out_illegal}, 64'd1);
      chk("R11 no valid", {63'd0, out_valid}, 64'd0);
      @(negedge clk);
      chk("R11 one cycle", {63'd0, out_illegal}, 64'd0);
    end
    issue(enc(6'b000000, 5'd1, 5'd6, 5'd7, 5'd0), 64'h0000_0000_0000_0081, 64'h0, 1'b0);
    chk("R11 word ok", {62'd0, out_valid, out_illegal}, 64'd2);
    chk("R11 word data", out_data, 64'h0000_0000_0000_0081);
  endtask

  task automatic t_foreign;
    issue({6'b011110, 26'h0_1234}, 64'hFF, 64'h0, 1'b1);
    chk("R2 opcode", {62'd0, out_valid, out_illegal}, 64'd0);
    issue(enc(6'b001000, 5'd1, 5'd2, 5'd3, 5'd0), 64'hFF, 64'h0, 1'b1);
    chk("R2 func", {62'd0, out_valid, out_illegal}, 64'd0);
    issue(enc(6'b100011, 5'd1, 5'd2, 5'd3, 5'd0), 64'hFF, 64'h0, 1'b0);
    chk("R2 func hi", {62'd0, out_valid, out_illegal}, 64'd0);
  endtask

  task automatic t_empty_insert;
    run_op("R12 word", 6'b000100, 5'd3, 5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    run_op("R12 dword", 6'b000111, 5'd2, 5'd30, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    run_op("R12 upper", 6'b000110, 5'd1, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210);
    chk("R12 model", model(6'b000111, 64'hF, 64'h55, 2, 30), 64'h55);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    t_word_extract();
    t_dext();
    t_dextm();
    t_dextu();
    t_ins();
    t_dins();
    t_dinsm();
    t_dinsu();
    t_mode_fault();
    t_foreign();
    t_empty_insert();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule